// File: doc/BRIEF.md
# Direction-Configurable Chip-Select Port

This block is an eight-pin bidirectional port. Its pins normally serve as active-low chip selects for serial peripherals. Software picks the direction of each pin through a direction register. It sets the level of each output pin through a port register. Reading the port back returns the synchronised level of the input pins and a 1 for every output pin.

A transfer engine placed next to the port can frame a transfer. It does this by pulling the chip select of any output pin low through an active-low request vector. The request combines with the software bit by a logical AND. A request can therefore only pull a pin low. A pin that software holds at 0 stays low during a request and after the request ends.

A build parameter limits how many pins are usable. Pins above that limit are fixed as inputs, and the direction register ignores writes to them.

Top module: `cs_ioport`

## Requirements
- R1: After reset every pin is an input: `pin_oe` is 0x00, `pin_out` is 0xFF, and the stored port bits are all 1.
- R2: Bit i of the direction register set to 1 makes pin i an input (`pin_oe[i]`=0). Set to 0, it makes pin i an output (`pin_oe[i]`=1). A direction write takes effect one clock after the strobe.
- R3: A port write updates only the bits of pins that are outputs at the time of the write. Bits of input pins keep their stored value, and that value is seen on `pin_out` once the pin is later turned into an output.
- R4: `rd_data[i]` is 1 for an output pin. For an input pin it is the level of `pin_in[i]`, delayed by exactly two clock edges.
- R5: While software holds an output bit at 0, the pin stays low whatever the request bit does, including after a request ends.
- R6: An output pin whose stored bit is 1 goes low in the same cycle that `hw_req_n[i]` is 0. It returns high in the same cycle that the request is released.
- R7: A request on an input pin does not enable the pin's driver: `pin_oe[i]` stays 0 and `pin_out[i]` stays 1.
- R8: With `USED_PINS` below `NPINS`, pins at index `USED_PINS` and above remain inputs whatever value is written to the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_wr | input | 1 | Write strobe for the direction register |
| port_wr | input | 1 | Write strobe for the port register |
| wdata | input | NPINS | Write data for either register |
| rd_data | output | NPINS | Port readback: input levels, 1 for outputs |
| hw_req_n | input | NPINS | Active-low chip-select request from the transfer engine |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad output enables, 1 = drive |

## Verification
Random mixes of direction writes, port writes, request vectors and pad levels are applied. Mixed directions separate the output path from the readback path, and they show whether writes to input bits leak into the stored value.

Directed sequences cover the following cases:
- A bit held low by software across a request and its release. This separates an AND combine from a hardware override.
- A request on a pin that is still an input.
- A pad change sampled after one edge and after two edges. This pins down the synchroniser depth.
- A second instance with four usable pins, which shows that the upper pins are locked as inputs.

// File: rtl/cs_ioport_pkg.sv
// Package: shared encodings for the chip-select port.
// Assumes: one direction bit per pin, 1 = input.
package cs_ioport_pkg;
    localparam logic DIR_IN  = 1'b1;
    localparam logic DIR_OUT = 1'b0;
    localparam logic PIN_IDLE = 1'b1;   // deselected / undriven level
endpackage

// File: rtl/cs_dir_reg.sv
// Direction register: one bit per pin, 1 = input.
// Assumes: bits at USED_PINS and above are forced to input on every write.
module cs_dir_reg #(
    parameter int NPINS     = 8,
    parameter int USED_PINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dir_q
);
    import cs_ioport_pkg::*;

    localparam logic [NPINS-1:0] FIXED_IN = ~({NPINS{1'b1}} >> (NPINS - USED_PINS));

    // Load the direction bits; unusable pins stay inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= {NPINS{DIR_IN}};
        else if (wr_en)
            dir_q <= wdata | FIXED_IN;
    end

    // R8: unusable pins never become outputs
    a_r8_fixed_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((dir_q & FIXED_IN) == FIXED_IN));
endmodule

// File: rtl/cs_port_reg.sv
// Port register: the software chip-select levels.
// Assumes: a write touches only bits whose pin is an output at write time.
module cs_port_reg #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] port_q
);
    import cs_ioport_pkg::*;

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        // Update one bit on a write when its pin drives.
        always_ff @(posedge clk) begin
            if (!rst_n)
                port_q[i] <= PIN_IDLE;
            else if (wr_en && dir_q[i] == DIR_OUT)
                port_q[i] <= wdata[i];
        end

        // R3: writes leave input-pin bits untouched
        a_r3_input_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && dir_q[i] == DIR_IN) |=> $stable(port_q[i]));
    end
endmodule

// File: rtl/cs_in_sync.sv
// Two-flop synchroniser for the pad inputs.
// Assumes: pads are asynchronous to clk; reset level is the idle level.
module cs_in_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] sync_q
);
    logic [NPINS-1:0] meta_q;

    // Shift the pad levels through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end
endmodule

// File: rtl/cs_pin_merge.sv
// Pin merge: combines software bits with hardware requests, builds enables and readback.
// Assumes: hw_req_n is active low and already in the clk domain.
module cs_pin_merge #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] port_q,
    input  logic [NPINS-1:0] hw_req_n,
    input  logic [NPINS-1:0] sync_q,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] rd_data
);
    import cs_ioport_pkg::*;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Drive level, enable and readback for one pin.
        always_comb begin
            pin_oe[i]  = (dir_q[i] == DIR_OUT);
            pin_out[i] = pin_oe[i] ? (port_q[i] & hw_req_n[i]) : PIN_IDLE;
            rd_data[i] = (dir_q[i] == DIR_IN) ? sync_q[i] : 1'b1;
        end

        // R5: a software low always wins
        a_r5_sw_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_oe[i] && !port_q[i]) |-> !pin_out[i]);
        // R6: a request pulls a driven pin low
        a_r6_req_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_oe[i] && !hw_req_n[i]) |-> !pin_out[i]);
        // R4: output pins read back as 1
        a_r4_out_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[i] |-> rd_data[i]);
        // R7: undriven pins sit at the idle level
        a_r7_idle_when_input: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_oe[i] |-> pin_out[i]);
    end
endmodule

// File: rtl/cs_ioport.sv
// Top: direction-configurable chip-select port.
// Assumes: one write strobe per register; wdata is shared by both registers.
module cs_ioport #(
    parameter int NPINS     = 8,
    parameter int USED_PINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_wr,
    input  logic             port_wr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] rd_data,
    input  logic [NPINS-1:0] hw_req_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);
    localparam logic [NPINS-1:0] USED_MASK = {NPINS{1'b1}} >> (NPINS - USED_PINS);

    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] port_q;
    logic [NPINS-1:0] sync_q;

    cs_dir_reg #(.NPINS(NPINS), .USED_PINS(USED_PINS)) u_dir (
        .clk(clk), .rst_n(rst_n), .wr_en(dir_wr), .wdata(wdata), .dir_q(dir_q));

    cs_port_reg #(.NPINS(NPINS)) u_port (
        .clk(clk), .rst_n(rst_n), .wr_en(port_wr), .wdata(wdata),
        .dir_q(dir_q), .port_q(port_q));

    cs_in_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_q(sync_q));

    cs_pin_merge #(.NPINS(NPINS)) u_merge (
        .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .port_q(port_q),
        .hw_req_n(hw_req_n), .sync_q(sync_q),
        .pin_out(pin_out), .pin_oe(pin_oe), .rd_data(rd_data));

    // R2: the enables follow the written direction one clock later
    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (pin_oe == (~$past(wdata) & USED_MASK)));
endmodule

// File: tb/cs_ioport_test.sv
module cs_ioport_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dir_wr = 1'b0;
    logic         port_wr = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] hw_req_n = '1;
    logic [N-1:0] pin_in = '1;
    logic [N-1:0] rd_data, pin_out, pin_oe;
    logic [N-1:0] rd_s, out_s, oe_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [N-1:0] m_dir  = '1;
    logic [N-1:0] m_port = '1;

    always #2 clk = ~clk;

    cs_ioport #(.NPINS(N), .USED_PINS(8)) uut (
        .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .port_wr(port_wr), .wdata(wdata),
        .rd_data(rd_data), .hw_req_n(hw_req_n), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe));

    cs_ioport #(.NPINS(N), .USED_PINS(4)) uut_s (
        .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .port_wr(port_wr), .wdata(wdata),
        .rd_data(rd_s), .hw_req_n(hw_req_n), .pin_in(pin_in),
        .pin_out(out_s), .pin_oe(oe_s));

    function automatic logic [N-1:0] f_oe(logic [N-1:0] d);
        return ~d;
    endfunction
    function automatic logic [N-1:0] f_out(logic [N-1:0] d, logic [N-1:0] p, logic [N-1:0] h);
        return d | (p & h);
    endfunction
    function automatic logic [N-1:0] f_rd(logic [N-1:0] d, logic [N-1:0] pin);
        return (d & pin) | ~d;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_dir(logic [N-1:0] v);
        @(negedge clk); dir_wr = 1'b1; wdata = v;
        @(negedge clk); dir_wr = 1'b0;
        m_dir = v;
    endtask

    task automatic wr_port(logic [N-1:0] v);
        @(negedge clk); port_wr = 1'b1; wdata = v;
        @(negedge clk); port_wr = 1'b0;
        m_port = (m_port & m_dir) | (v & ~m_dir);
    endtask

    task automatic check_all(string req);
        check(req, pin_oe, f_oe(m_dir));
        check(req, pin_out, f_out(m_dir, m_port, hw_req_n));
        check(req, rd_data, f_rd(m_dir, pin_in));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'hFF);
        check("R1 rd", rd_data, 8'hFF);

        // R3: write 0 to input bit 2, then make it an output: stays 1
        wr_port(8'h00);
        check("R3 out while input", pin_out, 8'hFF);
        wr_dir(8'hFB);
        check("R2 oe", pin_oe, 8'h04);
        check("R3 stored bit kept", pin_out, 8'hFF);
        check("R4 out reads 1", rd_data[2] ? 8'h01 : 8'h00, 8'h01);

        // R6: request pulls bit 2 low in the same cycle, release restores
        @(negedge clk); hw_req_n = 8'hFB; #1;
        check("R6 pulled low", pin_out, 8'hFB);
        hw_req_n = 8'hFF; #1;
        check("R6 released", pin_out, 8'hFF);

        // R5: software holds bit 2 low across a request
        wr_port(8'hFB);
        check("R5 sw low", pin_out, 8'hFB);
        @(negedge clk); hw_req_n = 8'hFB;
        @(negedge clk); check("R5 during req", pin_out, 8'hFB);
        hw_req_n = 8'hFF;
        @(negedge clk); check("R5 after req", pin_out, 8'hFB);

        // R7: request on input pin 5
        @(negedge clk); hw_req_n = 8'hDF; #1;
        check("R7 oe", pin_oe, 8'h04);
        check("R7 out", pin_out, 8'hFB);
        hw_req_n = 8'hFF;

        // R4: two-edge latency on input pin 0
        @(negedge clk); pin_in = 8'hFE;
        @(negedge clk); check("R4 after one edge", rd_data, 8'hFF);
        @(negedge clk); check("R4 after two edges", rd_data, 8'hFE);
        pin_in = 8'hFF;
        repeat (2) @(negedge clk);

        // R8: reduced instance keeps pins 4..7 as inputs
        wr_dir(8'h00);
        check("R8 oe small", oe_s, 8'h0F);
        check("R2 oe full", pin_oe, 8'hFF);
        @(negedge clk); pin_in = 8'h5A;
        repeat (2) @(negedge clk);
        check("R8 rd small", rd_s, 8'h5F);
        wr_dir(8'hFF);
        wr_port(8'hFF);

        // random mix: R2 R3 R4 R6
        for (int k = 0; k < 400; k++) begin
            int op = $urandom_range(0, 2);
            if (op == 0) wr_dir(N'($urandom));
            else if (op == 1) wr_port(N'($urandom));
            @(negedge clk);
            pin_in   = N'($urandom);
            hw_req_n = N'($urandom) | N'($urandom);
            repeat (2) @(negedge clk);
            check_all("R2/R3/R4/R6 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule